// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder

This block is the device-side command front end of a single-data-rate synchronous DRAM with two banks. On every rising clock edge where clock enable is high, it looks at chip select and the three strobes, the address bus, the bank-select bit and the data mask. From these it works out whether the cycle carries an activate, read, write, precharge or no-operation. It keeps an open/idle flag and the open row address for each bank. For reads and writes it reports the column that was accepted. It raises an error pulse for commands that do not fit the bank state, and it produces auto-precharge requests when a burst ends.

The data mask feeds two separate paths. On the write path it gates the write-commit strobe in the same cycle. On the read path it passes through a two-stage pipeline before it gates the output enable. Bursts are BURST_LEN beats long. A burst starts in the cycle of the command, and read data beats are seen at the output RD_LAT cycles later. When clock enable is low, every register holds its value and no command is accepted.

Top module: `twobank_cmd_decoder`

## Requirements
- R1: After a synchronous reset, both banks are idle, both row outputs are zero, and `col_valid`, `cmd_err`, `ap_req`, `rd_oe` and `wr_commit` are low.
- R2: A command is taken only in a cycle where `cs_n` is low and `cke` is high. A cycle with `cs_n` high, or a strobe code {ras_n,cas_n,we_n} other than 011, 101, 100 or 010, changes no bank state and gives no `col_valid` or `cmd_err`.
- R3: Activate is code 011. It opens bank `bank_sel` (0 is bank A, 1 is bank B) and stores `addr[10:0]` as that bank's row. The effect shows in `bank_open[bank_sel]` and in `row_bank0` or `row_bank1` one cycle later.
- R4: Read is code 101 and write is code 100. Either one sent to an open bank pulses `col_valid` one cycle later, with `col_addr` set to `addr[9:0]`, `col_bank` set to `bank_sel`, and `col_is_wr` high only for a write.
- R5: A read or write sent to an idle bank, or an activate sent to an open bank, pulses `cmd_err` one cycle later. That command changes no bank state and gives no `col_valid`.
- R6: Precharge is code 010. With `addr[10]` high it closes both banks whatever `bank_sel` is. With `addr[10]` low it closes only bank `bank_sel`. A precharge that closes the bank of a pending auto-precharge cancels that request.
- R7: A read or write with `addr[10]` high asks for auto-precharge. After the last of the BURST_LEN beats (the command cycle is beat one), `ap_req` pulses one-hot for that bank and the bank closes in the same cycle. A new accepted read or write before that point ends the earlier burst and drops its request.
- R8: During a write beat, `wr_commit` is high in the same cycle exactly when `dqm` is low and `cke` is high.
- R9: `rd_oe` is high in the cycle two clocked cycles after a read beat, and only if `dqm` was low in that beat's cycle.
- R10: While `cke` is low, all registered outputs and bank state hold their values and `wr_commit` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | 1 | Bank select (0 = A, 1 = B) |
| addr | input | 11 | Address bus; bit 10 is the auto-precharge / all-banks bit |
| dqm | input | 1 | Data mask |
| bank_open | output | 2 | Per-bank open flag |
| row_bank0 | output | 11 | Row held for bank A |
| row_bank1 | output | 11 | Row held for bank B |
| col_valid | output | 1 | Pulse for an accepted read or write |
| col_is_wr | output | 1 | Accepted column command was a write |
| col_bank | output | 1 | Bank of the accepted column command |
| col_addr | output | 10 | Column of the accepted command |
| cmd_err | output | 1 | Pulse for an illegal command |
| ap_req | output | 2 | One-hot auto-precharge request pulse |
| rd_oe | output | 1 | Read output enable after mask latency |
| wr_commit | output | 1 | Write beat allowed by the mask this cycle |

## Verification
The bench aims at the cycles where the two meanings of address bit 10 meet. It sends an auto-precharge read whose bank is then closed by hand and opened again, so a design that does not cancel the pending request would close the new row. It sends a write with auto-precharge that a read cuts short, so a design that keeps the stale request would close a bank that should stay open. It also lines up mask toggles against the two different latencies: a read mask applied with no delay, or a write mask applied late, shows up at once as an output-enable or commit bit on the wrong beat. Cycles with clock enable low fall in the middle of a burst and while a pulse is showing, so a design that keeps counting or clears its pulses while frozen moves away from the reference.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int ADDR_W = 11;
    localparam int COL_W  = 10;
    localparam int NBANK  = 2;
    localparam int AP_BIT = ADDR_W - 1;

    localparam logic [2:0] CODE_ACT = 3'b011;
    localparam logic [2:0] CODE_RD  = 3'b101;
    localparam logic [2:0] CODE_WR  = 3'b100;
    localparam logic [2:0] CODE_PRE = 3'b010;

    typedef enum logic [2:0] {
        K_NONE,
        K_ACT,
        K_RD,
        K_WR,
        K_PRE
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic               bank;
        logic [ADDR_W-1:0]  addr;
    } cmd_req_t;

    function automatic cmd_kind_e classify(logic [2:0] code);
        case (code)
            CODE_ACT: return K_ACT;
            CODE_RD:  return K_RD;
            CODE_WR:  return K_WR;
            CODE_PRE: return K_PRE;
            default:  return K_NONE;
        endcase
    endfunction

    function automatic logic [NBANK-1:0] bank_onehot(logic b);
        logic [NBANK-1:0] v;
        v = '0;
        v[b] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic               cke,
    input  logic               cs_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic               bank_sel,
    input  logic [ADDR_W-1:0]  addr,
    output cmd_req_t           req
);

    always_comb begin
        req.bank = bank_sel;
        req.addr = addr;
        if (cke && !cs_n)
            req.kind = classify({ras_n, cas_n, we_n});
        else
            req.kind = K_NONE;
    end

endmodule

// File: rtl/sdcmd_bank_slot.sv
module sdcmd_bank_slot
    import sdcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cke,
    input  logic               open_req,
    input  logic               close_req,
    input  logic [ADDR_W-1:0]  row_in,
    output logic               is_open,
    output logic [ADDR_W-1:0]  row
);

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            row     <= '0;
        end else if (cke) begin
            if (open_req) begin
                is_open <= 1'b1;
                row     <= row_in;
            end else if (close_req) begin
                is_open <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdcmd_burst.sv
module sdcmd_burst
    import sdcmd_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              start,
    input  logic              start_rd,
    input  logic              start_bank,
    input  logic              start_ap,
    input  logic [NBANK-1:0]  pre_mask,
    output logic              rd_beat,
    output logic              wr_beat,
    output logic [NBANK-1:0]  ap_fire
);

    localparam int BW = $clog2(BURST_LEN + 1);
    localparam logic [BW-1:0] RELOAD = BW'(BURST_LEN - 1);

    logic [BW-1:0] beats_q;
    logic          rd_q;
    logic          bank_q;
    logic          ap_q;
    logic          last;
    logic          pre_kill;
    logic          busy;

    assign busy     = (beats_q != '0);
    assign last     = (beats_q == BW'(1)) && !start;
    assign pre_kill = pre_mask[bank_q];

    always_comb begin
        ap_fire = '0;
        if (cke && last && ap_q && !pre_kill)
            ap_fire = bank_onehot(bank_q);
    end

    assign rd_beat = (start && start_rd)  || (busy && rd_q);
    assign wr_beat = (start && !start_rd) || (busy && !rd_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_q <= '0;
            rd_q    <= 1'b0;
            bank_q  <= 1'b0;
            ap_q    <= 1'b0;
        end else if (cke) begin
            if (start) begin
                beats_q <= RELOAD;
                rd_q    <= start_rd;
                bank_q  <= start_bank;
                ap_q    <= start_ap;
            end else begin
                if (busy)
                    beats_q <= beats_q - BW'(1);
                if (pre_kill || last)
                    ap_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdcmd_mask.sv
module sdcmd_mask #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic dqm,
    input  logic rd_beat,
    input  logic wr_beat,
    output logic rd_oe,
    output logic wr_commit
);

    logic [RD_LAT-1:0] beat_sr;
    logic [RD_LAT-1:0] mask_sr;

    generate
        if (RD_LAT == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    beat_sr <= '0;
                    mask_sr <= '0;
                end else if (cke) begin
                    beat_sr <= rd_beat;
                    mask_sr <= dqm;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    beat_sr <= '0;
                    mask_sr <= '0;
                end else if (cke) begin
                    beat_sr <= {beat_sr[RD_LAT-2:0], rd_beat};
                    mask_sr <= {mask_sr[RD_LAT-2:0], dqm};
                end
            end
        end
    endgenerate

    assign rd_oe     = beat_sr[RD_LAT-1] && !mask_sr[RD_LAT-1];
    assign wr_commit = cke && wr_beat && !dqm;

endmodule

// File: rtl/twobank_cmd_decoder.sv
module twobank_cmd_decoder
    import sdcmd_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int RD_LAT    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cke,
    input  logic               cs_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic               bank_sel,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               dqm,
    output logic [NBANK-1:0]   bank_open,
    output logic [ADDR_W-1:0]  row_bank0,
    output logic [ADDR_W-1:0]  row_bank1,
    output logic               col_valid,
    output logic               col_is_wr,
    output logic               col_bank,
    output logic [COL_W-1:0]   col_addr,
    output logic               cmd_err,
    output logic [NBANK-1:0]   ap_req,
    output logic               rd_oe,
    output logic               wr_commit
);

    cmd_req_t           req;
    logic               sel_open;
    logic               is_rw;
    logic               act_ok;
    logic               rw_ok;
    logic               bad_cmd;
    logic [NBANK-1:0]   pre_mask;
    logic [NBANK-1:0]   ap_fire;
    logic               rd_beat;
    logic               wr_beat;
    logic [ADDR_W-1:0]  row_q [NBANK];

    sdcmd_decode u_dec (
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .bank_sel (bank_sel),
        .addr     (addr),
        .req      (req)
    );

    assign sel_open = bank_open[req.bank];
    assign is_rw    = (req.kind == K_RD) || (req.kind == K_WR);
    assign act_ok   = (req.kind == K_ACT) && !sel_open;
    assign rw_ok    = is_rw && sel_open;
    assign bad_cmd  = ((req.kind == K_ACT) && sel_open) || (is_rw && !sel_open);

    always_comb begin
        pre_mask = '0;
        if (req.kind == K_PRE)
            pre_mask = req.addr[AP_BIT] ? '1 : bank_onehot(req.bank);
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            sdcmd_bank_slot u_slot (
                .clk       (clk),
                .rst       (rst),
                .cke       (cke),
                .open_req  (act_ok && (req.bank == 1'(b))),
                .close_req (pre_mask[b] || ap_fire[b]),
                .row_in    (req.addr),
                .is_open   (bank_open[b]),
                .row       (row_q[b])
            );
        end
    endgenerate

    assign row_bank0 = row_q[0];
    assign row_bank1 = row_q[1];

    sdcmd_burst #(
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk        (clk),
        .rst        (rst),
        .cke        (cke),
        .start      (rw_ok),
        .start_rd   (req.kind == K_RD),
        .start_bank (req.bank),
        .start_ap   (req.addr[AP_BIT]),
        .pre_mask   (pre_mask),
        .rd_beat    (rd_beat),
        .wr_beat    (wr_beat),
        .ap_fire    (ap_fire)
    );

    sdcmd_mask #(
        .RD_LAT (RD_LAT)
    ) u_mask (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .dqm       (dqm),
        .rd_beat   (rd_beat),
        .wr_beat   (wr_beat),
        .rd_oe     (rd_oe),
        .wr_commit (wr_commit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            col_valid <= 1'b0;
            col_is_wr <= 1'b0;
            col_bank  <= 1'b0;
            col_addr  <= '0;
            cmd_err   <= 1'b0;
            ap_req    <= '0;
        end else if (cke) begin
            col_valid <= rw_ok;
            cmd_err   <= bad_cmd;
            ap_req    <= ap_fire;
            if (rw_ok) begin
                col_is_wr <= (req.kind == K_WR);
                col_bank  <= req.bank;
                col_addr  <= req.addr[COL_W-1:0];
            end
        end
    end

endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker
    import sdcmd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cke,
    input logic               cs_n,
    input logic               ras_n,
    input logic               cas_n,
    input logic               we_n,
    input logic               bank_sel,
    input logic [ADDR_W-1:0]  addr,
    input logic               dqm,
    input logic [NBANK-1:0]   bank_open,
    input logic [ADDR_W-1:0]  row_bank0,
    input logic [ADDR_W-1:0]  row_bank1,
    input logic               col_valid,
    input logic               col_bank,
    input logic               cmd_err,
    input logic [NBANK-1:0]   ap_req,
    input logic               rd_oe,
    input logic               wr_commit
);

    logic [2:0] code;
    logic       live;
    assign code = {ras_n, cas_n, we_n};
    assign live = cke && !cs_n;

    AST_CS_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (cs_n && cke) |=> (!col_valid && !cmd_err && ((bank_open & ~$past(bank_open)) == '0))); // R2

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (live && code == CODE_ACT && !bank_open[bank_sel]) |=>
            (bank_open[$past(bank_sel)] &&
             (($past(bank_sel) ? row_bank1 : row_bank0) == $past(addr)))); // R3

    AST_COL_OPEN: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> bank_open[col_bank]); // R4

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> !col_valid); // R5

    AST_PRE_ALL: assert property (@(posedge clk) disable iff (rst)
        (live && code == CODE_PRE && addr[AP_BIT]) |=> (bank_open == '0)); // R6

    AST_AP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ap_req)); // R7

    AST_AP_CLOSED: assert property (@(posedge clk) disable iff (rst)
        ((ap_req & bank_open) == '0)); // R7

    AST_WR_MASK: assert property (@(posedge clk) disable iff (rst)
        (dqm || !cke) |-> !wr_commit); // R8

    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ($stable(bank_open) && $stable(col_valid) && $stable(cmd_err) &&
                  $stable(ap_req) && $stable(rd_oe))); // R10

endmodule

bind twobank_cmd_decoder sdcmd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .bank_sel  (bank_sel),
    .addr      (addr),
    .dqm       (dqm),
    .bank_open (bank_open),
    .row_bank0 (row_bank0),
    .row_bank1 (row_bank1),
    .col_valid (col_valid),
    .col_bank  (col_bank),
    .cmd_err   (cmd_err),
    .ap_req    (ap_req),
    .rd_oe     (rd_oe),
    .wr_commit (wr_commit)
);

// File: tb/twobank_cmd_decoder_tb.sv
`timescale 1ns/1ps
module twobank_cmd_decoder_tb_top;

    localparam int BL = 4;
    localparam logic [2:0] OP_ACT = 3'b011;
    localparam logic [2:0] OP_RD  = 3'b101;
    localparam logic [2:0] OP_WR  = 3'b100;
    localparam logic [2:0] OP_PRE = 3'b010;
    localparam logic [2:0] OP_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic        bank_sel = 1'b0;
    logic [10:0] addr = '0;
    logic        dqm = 1'b0;
    logic [1:0]  bank_open;
    logic [10:0] row_bank0;
    logic [10:0] row_bank1;
    logic        col_valid;
    logic        col_is_wr;
    logic        col_bank;
    logic [9:0]  col_addr;
    logic        cmd_err;
    logic [1:0]  ap_req;
    logic        rd_oe;
    logic        wr_commit;

    int n_checks = 0;
    int n_fails  = 0;
    bit run      = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    twobank_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .addr(addr),
        .dqm(dqm), .bank_open(bank_open), .row_bank0(row_bank0),
        .row_bank1(row_bank1), .col_valid(col_valid), .col_is_wr(col_is_wr),
        .col_bank(col_bank), .col_addr(col_addr), .cmd_err(cmd_err),
        .ap_req(ap_req), .rd_oe(rd_oe), .wr_commit(wr_commit)
    );

    // reference model state
    int m_open [2];
    int m_row  [2];
    int m_ap   [2];
    int m_colv, m_cola, m_colb, m_colw, m_err;
    int m_beats, m_brd, m_bbank, m_bap;
    int rdh [2];
    int mkh [2];
    int hit [2];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_open[i] = 0; m_row[i] = 0; m_ap[i] = 0; rdh[i] = 0; mkh[i] = 0;
            end
            m_colv = 0; m_cola = 0; m_colb = 0; m_colw = 0; m_err = 0;
            m_beats = 0; m_brd = 0; m_bbank = 0; m_bap = 0;
        end else if (cke) begin
            int code, b, a10, v, is_act, is_rd, is_wr, is_pre, rw, actok, last, fire, rbeat;
            code = int'({ras_n, cas_n, we_n});
            v = int'(!cs_n);
            b = int'(bank_sel);
            a10 = int'(addr[10]);
            is_act = v && code == 3; is_rd = v && code == 5;
            is_wr = v && code == 4;  is_pre = v && code == 2;
            rw = (is_rd || is_wr) && m_open[b];
            actok = is_act && !m_open[b];
            for (int i = 0; i < 2; i++) hit[i] = is_pre && (a10 || b == i);
            last = (m_beats == 1) && !rw;
            fire = last && m_bap && !hit[m_bbank];
            rbeat = (rw && is_rd) || (m_beats != 0 && m_brd);
            m_ap[0] = 0; m_ap[1] = 0;
            if (fire) m_ap[m_bbank] = 1;
            m_err = (is_act && m_open[b]) || ((is_rd || is_wr) && !m_open[b]);
            m_colv = rw;
            if (rw) begin
                m_cola = int'(addr) % 1024; m_colb = b; m_colw = is_wr;
            end
            for (int i = 0; i < 2; i++) begin
                if (actok && b == i) begin
                    m_open[i] = 1; m_row[i] = int'(addr);
                end else if (hit[i] || m_ap[i]) begin
                    m_open[i] = 0;
                end
            end
            rdh[1] = rdh[0]; rdh[0] = rbeat;
            mkh[1] = mkh[0]; mkh[0] = int'(dqm);
            if (rw) begin
                m_beats = BL - 1; m_brd = is_rd; m_bbank = b; m_bap = a10;
            end else begin
                if (m_beats != 0) m_beats--;
                if (hit[m_bbank] || last) m_bap = 0;
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (run && !finished) begin
            int code, exp_wc;
            code = int'({ras_n, cas_n, we_n});
            exp_wc = cke && !dqm &&
                     ((!cs_n && code == 4 && m_open[int'(bank_sel)]) || (m_beats != 0 && !m_brd));
            chk("R3", "bank_open", int'(bank_open), m_open[1] * 2 + m_open[0]);
            chk("R3", "row_bank0", int'(row_bank0), m_row[0]);
            chk("R3", "row_bank1", int'(row_bank1), m_row[1]);
            chk("R4", "col_valid", int'(col_valid), m_colv);
            if (m_colv) begin
                chk("R4", "col_addr", int'(col_addr), m_cola);
                chk("R4", "col_bank", int'(col_bank), m_colb);
                chk("R4", "col_is_wr", int'(col_is_wr), m_colw);
            end
            chk("R5", "cmd_err", int'(cmd_err), m_err);
            chk("R7", "ap_req", int'(ap_req), m_ap[1] * 2 + m_ap[0]);
            chk("R9", "rd_oe", int'(rd_oe), rdh[1] && !mkh[1]);
            chk("R8", "wr_commit", int'(wr_commit), exp_wc);
        end
    end

    task automatic drive(input logic c_n, input logic [2:0] op, input logic b,
                         input logic [10:0] a, input logic m, input logic ck);
        @(posedge clk);
        #1;
        cs_n = c_n; {ras_n, cas_n, we_n} = op; bank_sel = b; addr = a; dqm = m; cke = ck;
        @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] op, input logic b, input logic [10:0] a);
        drive(1'b0, op, b, a, 1'b0, 1'b1);
    endtask

    task automatic idle(input logic m);
        drive(1'b1, OP_NOP, 1'b0, 11'h000, m, 1'b1);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "bank_open", int'(bank_open), 0);
        chk("R1", "rows", int'(row_bank0) + int'(row_bank1), 0);
        chk("R1", "pulses", int'(col_valid) + int'(cmd_err) + int'(ap_req), 0);
        chk("R1", "rd_oe/wr_commit", int'(rd_oe) + int'(wr_commit), 0);
        run = 1'b1;

        // R3 activates
        cmd(OP_ACT, 1'b0, 11'h5A5);
        cmd(OP_ACT, 1'b1, 11'h7FF);
        chk("R3", "bank A open", int'(bank_open), 1);
        chk("R3", "row A", int'(row_bank0), 11'h5A5);
        cmd(OP_ACT, 1'b0, 11'h123);
        chk("R3", "both open", int'(bank_open), 3);
        chk("R3", "row B", int'(row_bank1), 11'h7FF);

        // R8 write burst with zero-latency mask
        cmd(OP_WR, 1'b0, 11'h3FF);
        chk("R5", "act to open bank", int'(cmd_err), 1);
        chk("R5", "row A kept", int'(row_bank0), 11'h5A5);
        chk("R8", "beat1 commit", int'(wr_commit), 1);
        idle(1'b1);
        chk("R8", "beat2 masked", int'(wr_commit), 0);
        chk("R4", "write col", int'(col_valid) * 2048 + int'(col_is_wr) * 1024 + int'(col_addr), 2048 + 1024 + 10'h3FF);
        idle(1'b0);
        chk("R8", "beat3 commit", int'(wr_commit), 1);
        idle(1'b0);
        chk("R8", "beat4 commit", int'(wr_commit), 1);
        idle(1'b0);
        chk("R8", "after burst", int'(wr_commit), 0);

        // R9 read burst with two-cycle mask
        cmd(OP_RD, 1'b1, 11'h012);
        idle(1'b1);
        chk("R4", "read col", int'(col_valid) * 4 + int'(col_is_wr) * 2 + int'(col_bank), 5);
        idle(1'b0);
        chk("R9", "oe beat1", int'(rd_oe), 1);
        idle(1'b0);
        chk("R9", "oe beat2 masked", int'(rd_oe), 0);
        idle(1'b0);
        chk("R9", "oe beat3", int'(rd_oe), 1);
        idle(1'b0);
        chk("R9", "oe beat4", int'(rd_oe), 1);
        idle(1'b0);
        chk("R9", "oe after burst", int'(rd_oe), 0);

        // R6 single-bank precharge, then R5 read to idle bank
        cmd(OP_PRE, 1'b0, 11'h000);
        idle(1'b0);
        chk("R6", "only A closed", int'(bank_open), 2);
        cmd(OP_RD, 1'b0, 11'h010);
        idle(1'b0);
        chk("R5", "read idle err", int'(cmd_err), 1);
        chk("R5", "read idle no col", int'(col_valid), 0);

        // R7 auto-precharge on bank B
        cmd(OP_RD, 1'b1, 11'h445);
        idle(1'b0);
        idle(1'b0);
        idle(1'b0);
        chk("R7", "B open before end", int'(bank_open), 2);
        chk("R7", "no ap yet", int'(ap_req), 0);
        idle(1'b0);
        chk("R7", "ap for B", int'(ap_req), 2);
        chk("R7", "B closed", int'(bank_open), 0);
        idle(1'b0);
        chk("R7", "ap single pulse", int'(ap_req), 0);

        // R7 interrupted auto-precharge write
        cmd(OP_ACT, 1'b1, 11'h0AA);
        cmd(OP_WR, 1'b1, 11'h411);
        cmd(OP_RD, 1'b1, 11'h022);
        for (int i = 0; i < 6; i++) idle(1'b0);
        chk("R7", "interrupted keeps B", int'(bank_open), 2);

        // R6 precharge cancels pending auto-precharge
        cmd(OP_ACT, 1'b0, 11'h111);
        cmd(OP_RD, 1'b0, 11'h405);
        cmd(OP_PRE, 1'b0, 11'h000);
        cmd(OP_ACT, 1'b0, 11'h0F0);
        idle(1'b0);
        idle(1'b0);
        chk("R6", "cancelled ap", int'(ap_req), 0);
        chk("R6", "reopened A kept", int'(bank_open), 3);
        chk("R6", "new row A", int'(row_bank0), 11'h0F0);

        // R6 precharge all
        cmd(OP_PRE, 1'b0, 11'h400);
        idle(1'b0);
        chk("R6", "all closed", int'(bank_open), 0);

        // R2 deselected and unsupported codes
        drive(1'b1, OP_ACT, 1'b0, 11'h222, 1'b0, 1'b1);
        idle(1'b0);
        chk("R2", "cs high ignored", int'(bank_open) + int'(cmd_err), 0);
        cmd(3'b001, 1'b0, 11'h000);
        cmd(OP_ACT, 1'b1, 11'h333);
        chk("R2", "unsupported ignored", int'(bank_open) + int'(cmd_err) + int'(col_valid), 0);
        idle(1'b0);
        chk("R2", "B opened after", int'(bank_open), 2);

        // R10 clock-enable freeze
        cmd(OP_RD, 1'b1, 11'h001);
        drive(1'b0, OP_ACT, 1'b0, 11'h1AA, 1'b0, 1'b0);
        chk("R10", "col pulse shown", int'(col_valid), 1);
        drive(1'b0, OP_WR, 1'b1, 11'h400, 1'b0, 1'b0);
        chk("R10", "col pulse held", int'(col_valid), 1);
        chk("R10", "no commit", int'(wr_commit), 0);
        chk("R10", "banks held", int'(bank_open), 2);
        idle(1'b0);
        chk("R10", "still held", int'(col_valid), 1);
        chk("R10", "act ignored", int'(bank_open), 2);
        idle(1'b0);
        chk("R10", "pulse ends", int'(col_valid), 0);
        for (int i = 0; i < 6; i++) idle(1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule